// File: doc/BRIEF.md
# Narrowing Shift Right Unit

This block narrows a 128-bit vector of double-width lanes into 64 bits of half-width lanes. Each source lane is shifted right logically by an immediate amount. Before the shift, a rounding constant may be added, and the sum is kept at source width. The low half of each shifted lane is kept, and the packed 64-bit result is written into one half of a destination vector. The other half is either cleared or carried over from the old destination.

The lane width and the shift amount both come from a 7-bit immediate, split into a 4-bit high field and a 3-bit low field. Some high-field values are illegal and raise one of two error flags. When an error flag is raised, the old destination is passed through unchanged. All outputs are registered, so results appear one clock after the inputs are presented.

Top module: `narrow_shr`

## Requirements
- R1: When the high field is 4'b0000, `err_decode_o` is 1 and `err_rsvd_o` is 0, and `dst_o` equals the old destination `dst_i`.
- R2: When bit 3 of the high field is 1, `err_rsvd_o` is 1 and `err_decode_o` is 0, and `dst_o` equals `dst_i`. This holds for either value of Q and for any other immediate bits.
- R3: The narrow lane width is set by the highest set bit among high-field bits 2..0. Bit 2 selects 32 (source 64), bit 1 selects 16 (source 32), and bit 0 selects 8 (source 16). Lower set bits do not change the selection.
- R4: The shift amount is the source lane width minus the 7-bit value {high, low}. The shift is logical, and each result keeps only its low narrow-width bits.
- R5: With `round_i` set, 2^(shift-1) is added to each source lane before the shift. The sum wraps modulo 2^(source width).
- R6: With Q=0 and a legal immediate, the packed result is in `dst_o[63:0]` and `dst_o[127:64]` is zero.
- R7: With Q=1 and a legal immediate, the packed result is in `dst_o[127:64]` and `dst_o[63:0]` equals `dst_i[63:0]`.
- R8: Source lane i (bits i*S upward) lands in narrow slot i (bits i*E upward of the written half).
- R9: Outputs are registered: they reflect the inputs of the previous rising edge. Reset drives `dst_o` and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 128 | Source vector of double-width lanes |
| dst_i | input | 128 | Old destination vector |
| q_i | input | 1 | Selects the destination half: 0 for low, 1 for high |
| imm_hi_i | input | 4 | High immediate field |
| imm_lo_i | input | 3 | Low immediate field |
| round_i | input | 1 | Enables rounding before the shift |
| dst_o | output | 128 | New destination vector |
| err_decode_o | output | 1 | Immediate high field was zero |
| err_rsvd_o | output | 1 | Immediate used a reserved lane size |

## Verification
The assertions rely on the inputs being held steady through each rising edge, since they compare outputs against the previous cycle's inputs. They place no restriction on the immediate encodings. The stimulus changes inputs only on falling edges. It sweeps every value of both immediate fields, with both Q values, both rounding settings and several data patterns, so illegal encodings and legal ones are both exercised.

// File: rtl/narrow_shr.sv
module narrow_shr #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic             q_i,
  input  logic [3:0]       imm_hi_i,
  input  logic [2:0]       imm_lo_i,
  input  logic             round_i,
  output logic [VEC_W-1:0] dst_o,
  output logic             err_decode_o,
  output logic             err_rsvd_o
);
  localparam int HALF_W = VEC_W / 2;

  logic [6:0] imm7;
  assign imm7 = {imm_hi_i, imm_lo_i};

  for (genvar k = 0; k < 3; k++) begin : g_sz
    localparam int EW = 8 << k;
    localparam int SW = 2 * EW;
    localparam int NL = HALF_W / EW;
    logic [6:0]        sh;
    logic [SW-1:0]     rc;
    logic [HALF_W-1:0] packed_res;
    assign sh = 7'(SW) - imm7;
    assign rc = round_i ? (SW'(1) << (sh - 7'd1)) : '0;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [SW-1:0] sum;
      assign sum = src_i[l*SW +: SW] + rc;
      assign packed_res[l*EW +: EW] = EW'(sum >> sh);
    end
  end

  logic [HALF_W-1:0] narrow;
  assign narrow = imm_hi_i[2] ? g_sz[2].packed_res :
                  imm_hi_i[1] ? g_sz[1].packed_res : g_sz[0].packed_res;

  logic dec_err, rsv_err;
  assign dec_err = (imm_hi_i == 4'b0000);
  assign rsv_err = imm_hi_i[3];

  logic [VEC_W-1:0] dst_nxt;
  always_comb begin
    if (dec_err || rsv_err) dst_nxt = dst_i;
    else if (q_i)           dst_nxt = {narrow, dst_i[HALF_W-1:0]};
    else                    dst_nxt = {{HALF_W{1'b0}}, narrow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_o        <= '0;
      err_decode_o <= 1'b0;
      err_rsvd_o   <= 1'b0;
    end else begin
      dst_o        <= dst_nxt;
      err_decode_o <= dec_err;
      err_rsvd_o   <= rsv_err;
    end
  end

  p_decode_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_hi_i == 4'b0000) |=> (err_decode_o && !err_rsvd_o && dst_o == $past(dst_i)));

  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imm_hi_i[3] |=> (err_rsvd_o && !err_decode_o && dst_o == $past(dst_i)));

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_i && imm_hi_i != 4'b0000 && !imm_hi_i[3]) |=> (dst_o[VEC_W-1:HALF_W] == '0));

  p_lower_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_i && imm_hi_i != 4'b0000 && !imm_hi_i[3]) |=> (dst_o[HALF_W-1:0] == $past(dst_i[HALF_W-1:0])));

  p_flags_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_hi_i != 4'b0000 && !imm_hi_i[3]) |=> (!err_decode_o && !err_rsvd_o));
endmodule

// File: tb/narrow_shr_tb.sv
`timescale 1ns/1ps
module narrow_shr_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] src_i = '0, dst_i = '0;
  logic         q_i = 1'b0, round_i = 1'b0;
  logic [3:0]   imm_hi_i = '0;
  logic [2:0]   imm_lo_i = '0;
  logic [127:0] dst_o;
  logic         err_decode_o, err_rsvd_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  narrow_shr dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i), .q_i(q_i),
    .imm_hi_i(imm_hi_i), .imm_lo_i(imm_lo_i), .round_i(round_i),
    .dst_o(dst_o), .err_decode_o(err_decode_o), .err_rsvd_o(err_rsvd_o)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R3/R4/R5/R8: arithmetic model of one packed 64-bit result
  function automatic logic [63:0] model(logic [127:0] s, logic [3:0] hi, logic [2:0] lo, logic rnd);
    int e, w, sh;
    logic [127:0] lane, msk, res;
    logic [63:0] o;
    e = hi[2] ? 32 : hi[1] ? 16 : 8;
    w = 2 * e;
    sh = w - int'({hi, lo});
    msk = (128'h1 << w) - 1;
    o = '0;
    for (int i = 0; i < 64 / e; i++) begin
      lane = (s >> (i * w)) & msk;
      if (rnd) lane = (lane + (128'h1 << (sh - 1))) & msk;
      res = (lane >> sh) & ((128'h1 << e) - 1);
      o = o | 64'(res << (i * e));
    end
    return o;
  endfunction

  task automatic apply(logic [127:0] s, logic [127:0] d, logic q, logic [3:0] hi, logic [2:0] lo, logic rnd);
    logic [63:0] nw;
    @(negedge clk);
    src_i = s; dst_i = d; q_i = q; imm_hi_i = hi; imm_lo_i = lo; round_i = rnd;
    @(negedge clk);
    if (hi == 4'b0000) begin
      chk("R1 flags", {126'b0, err_decode_o, err_rsvd_o}, 128'b10);
      chk("R1 dst passthrough", dst_o, d);
    end else if (hi[3]) begin
      chk("R2 flags", {126'b0, err_decode_o, err_rsvd_o}, 128'b01);
      chk("R2 dst passthrough", dst_o, d);
    end else begin
      nw = model(s, hi, lo, rnd);
      chk("R9 flags clear", {126'b0, err_decode_o, err_rsvd_o}, 128'b0);
      if (q) chk("R7/R3/R4/R5/R8 high write", dst_o, {nw, d[63:0]});
      else   chk("R6/R3/R4/R5/R8 low write", dst_o, {64'b0, nw});
    end
  endtask

  initial begin
    logic [127:0] s, d;
    repeat (3) @(negedge clk);
    chk("R9 reset dst", dst_o, '0);
    chk("R9 reset flags", {126'b0, err_decode_o, err_rsvd_o}, '0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int h = 0; h < 16; h++) begin
        for (int l = 0; l < 8; l++) begin
          for (int m = 0; m < 4; m++) begin
            case (p)
              0: s = '1;
              1: s = {4{32'h8000_7f80}};
              default: s = {$urandom, $urandom, $urandom, $urandom};
            endcase
            d = {$urandom, $urandom, $urandom, $urandom};
            apply(s, d, m[0], 4'(h), 3'(l), m[1]);
          end
        end
      end
    end
    // R5: wrap at source width: 16-bit lanes of ffff, shift 1, rounding
    apply('1, '0, 1'b0, 4'b0001, 3'b111, 1'b1);
    chk("R5 wrap to zero", dst_o, '0);
    // R8: lane order with distinct 16-bit lanes, shift 8 -> high bytes
    apply(128'h0800_0700_0600_0500_0400_0300_0200_0100, '0, 1'b0, 4'b0001, 3'b000, 1'b0);
    chk("R8 lane order", dst_o, {64'b0, 64'h0807_0605_0403_0201});
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule